// File: doc/BRIEF.md
# Snapshot-Read 64-bit Free-Running Counter

This block holds a 64-bit up-counter that advances by one on every clock cycle where a tick-enable input is high. Three word-wide registers are exposed through a simple write-strobe and combinational read port: a control word, and two data words that show the low and high halves of a held snapshot of the counter.

Software never reads the live count. It first writes a latch request to the control word. After a short fixed delay, which stands in for a clock-domain crossing, the whole 64-bit value is copied into holding registers. Software then reads the low word followed by the high word. Both halves come from the same capture, so a carry between the halves between the two reads cannot tear the value.

A clear request uses the same mechanism to zero the counter. Each request bit reads back as 1 while its operation is pending and drops to 0 once the operation is done, so software can poll for completion. The control word also carries a two-bit clock-source field that is driven out to an external clock selector.

Top module: `lcnt_top`

## Requirements
- R1: While neither request completes, the counter rises by exactly one on each clock edge where `tick_en` is 1, and holds its value on edges where `tick_en` is 0.
- R2: Writing control bit 0 = 1 at offset 0xA0 starts a clear. Control bit 0 reads 1 while the clear is pending and reads 0 after it. When the clear completes the counter is zero, even if `tick_en` was high on that edge.
- R3: Writing control bit 1 = 1 starts a latch. Control bit 1 reads 1 while the latch is pending and reads 0 after it. When the latch completes, the snapshot holds the counter value of that cycle.
- R4: A read at offset 0xA4 returns snapshot bits 31:0 and a read at offset 0xA8 returns snapshot bits 63:32. The snapshot changes only when a latch completes, and writes to 0xA4 or 0xA8 have no effect.
- R5: Control bits 3:2 are a clock-source field. It is written by every control write, reads back in place, and drives `src_sel`. Code 0 selects the base oscillator, so a write of only the clear bit (value 0x1) leaves code 0 selected.
- R6: Each request reads as pending for exactly `SYNC_DLY` cycles after the write edge (`SYNC_DLY` at least 1, default 3). A request bit written while that request is already pending does not restart it.
- R7: The counter keeps counting while a snapshot is held, and a later latch overwrites the held value with the newer count.
- R8: When clear and latch are requested in the same write (value 0x3), the clear takes effect first and the snapshot holds zero.
- R9: After reset the counter, the snapshot, both pending bits and the source field are zero. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for the current cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| src_sel | output | 2 | Clock-source code for the external selector |

## Verification
The assertions assume that `tick_en`, `bus_wr`, `bus_addr` and `bus_wdata` change only away from the rising edge and are stable across it. The bench therefore drives every input on the falling edge. The assertions also assume that reset is applied at start-up before any request. The bench holds reset high for several cycles from time zero. Wherever an exact count is expected, the bench lowers `tick_en` while a latch or clear is pending. Only the tests for clear priority and clear-plus-latch keep ticks running through the completing edge.

// File: rtl/lcnt_pkg.sv
package lcnt_pkg;

    localparam int BUS_W   = 32;
    localparam int CNT_W   = 2 * BUS_W;
    localparam int ADDR_W  = 8;
    localparam int SRC_W   = 2;
    localparam int N_REQ   = 2;
    localparam int REQ_CLR = 0;
    localparam int REQ_LAT = 1;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_LOW  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_HIGH = 8'hA8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LOW,
        SEL_HIGH
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             lat;
        logic             clr;
    } ctrl_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL: return SEL_CTRL;
            OFS_LOW:  return SEL_LOW;
            OFS_HIGH: return SEL_HIGH;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lcnt_req_sync.sv
module lcnt_req_sync #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int EFF_DLY = (DLY < 1) ? 1 : DLY;
    localparam int CW      = $clog2(EFF_DLY + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= CW'(EFF_DLY);
        end else if (busy) begin
            if (remain == CW'(1)) busy <= 1'b0;
            remain <= remain - CW'(1);
        end
    end

    assign done = busy && (remain == CW'(1));

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R6
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R6

endmodule

// File: rtl/lcnt_counter.sv
module lcnt_counter
    import lcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             zero,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || zero) count <= '0;
        else if (tick)   count <= count + CNT_W'(1);
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        zero |=> (count == '0)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !zero) |=> (count == $past(count) + CNT_W'(1))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !zero) |=> $stable(count)); // R1

endmodule

// File: rtl/lcnt_snapshot.sv
module lcnt_snapshot
    import lcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             force_zero,
    input  logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)          held <= '0;
        else if (capture) held <= force_zero ? '0 : live;
    end

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(held)); // R4
    AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (capture && force_zero) |=> (held == '0)); // R8

endmodule

// File: rtl/lcnt_top.sv
module lcnt_top
    import lcnt_pkg::*;
#(
    parameter int SYNC_DLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [SRC_W-1:0]  src_sel
);
    reg_sel_e         sel;
    ctrl_t            wr_ctrl;
    logic             ctrl_wr;
    logic [N_REQ-1:0] req_start;
    logic [N_REQ-1:0] req_busy;
    logic [N_REQ-1:0] req_done;
    logic [SRC_W-1:0] src_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] held;
    ctrl_t            rd_ctrl;

    assign sel     = decode_sel(bus_addr);
    assign wr_ctrl = ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
    assign ctrl_wr = bus_wr && (sel == SEL_CTRL);

    assign req_start[REQ_CLR] = ctrl_wr && wr_ctrl.clr;
    assign req_start[REQ_LAT] = ctrl_wr && wr_ctrl.lat;

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        lcnt_req_sync #(.DLY(SYNC_DLY)) u_req (
            .clk   (clk),
            .rst   (rst),
            .start (req_start[g]),
            .busy  (req_busy[g]),
            .done  (req_done[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          src_q <= '0;
        else if (ctrl_wr) src_q <= wr_ctrl.src;
    end
    assign src_sel = src_q;

    lcnt_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_en),
        .zero  (req_done[REQ_CLR]),
        .count (count)
    );

    lcnt_snapshot u_snap (
        .clk        (clk),
        .rst        (rst),
        .capture    (req_done[REQ_LAT]),
        .force_zero (req_done[REQ_CLR]),
        .live       (count),
        .held       (held)
    );

    always_comb begin
        rd_ctrl     = '0;
        rd_ctrl.clr = req_busy[REQ_CLR];
        rd_ctrl.lat = req_busy[REQ_LAT];
        rd_ctrl.src = src_q;
        case (sel)
            SEL_CTRL: bus_rdata = BUS_W'(rd_ctrl);
            SEL_LOW:  bus_rdata = held[BUS_W-1:0];
            SEL_HIGH: bus_rdata = held[CNT_W-1:BUS_W];
            default:  bus_rdata = '0;
        endcase
    end

    AST_SRC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (src_sel == $past(wr_ctrl.src))); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (bus_rdata == '0)); // R9

endmodule

// File: tb/lcnt_top_test.sv
module lcnt_top_test;
    localparam int DLY = 3;
    localparam logic [7:0] A_CTRL = 8'hA0;
    localparam logic [7:0] A_LOW  = 8'hA4;
    localparam logic [7:0] A_HIGH = 8'hA8;
    localparam int NV = 5;
    localparam int unsigned VEC_TICKS [NV] = '{0, 1, 6, 19, 40};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  src_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lcnt_top #(.SYNC_DLY(DLY)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_sel(src_sel)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic poll(input logic [31:0] mask, output int n);
        logic [31:0] v;
        n = 0;
        rd(A_CTRL, v);
        while ((v & mask) != 0) begin
            n++;
            @(negedge clk);
            rd(A_CTRL, v);
        end
    endtask

    task automatic ticks(input int unsigned n);
        for (int unsigned i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        rd(A_CTRL, v); check("R9 ctrl reset", v, 32'h0);
        rd(A_LOW, v);  check("R9 low reset", v, 32'h0);
        rd(A_HIGH, v); check("R9 high reset", v, 32'h0);
        rd(8'h10, v);  check("R9 unmapped", v, 32'h0);
        check("R9 src reset", 32'(src_sel), 32'h0);

        // R6: exact pending duration for each request
        wr(A_CTRL, 32'h1); poll(32'h1, n); check("R6 clear busy cycles", 32'(n), 32'(DLY));
        wr(A_CTRL, 32'h2); poll(32'h2, n); check("R6 latch busy cycles", 32'(n), 32'(DLY));

        // R1/R3/R4: vector table, clear, count N ticks, latch, read halves
        for (int k = 0; k < NV; k++) begin
            wr(A_CTRL, 32'h1); poll(32'h1, n);
            ticks(VEC_TICKS[k]);
            wr(A_CTRL, 32'h2);
            rd(A_CTRL, v); check("R3 latch pending", v & 32'h2, 32'h2);
            poll(32'h2, n);
            rd(A_LOW, v);  check("R1 R3 low word", v, 32'(VEC_TICKS[k]));
            rd(A_HIGH, v); check("R4 high word", v, 32'h0);
        end

        // R7: counter runs while held, later latch overwrites
        ticks(7);
        rd(A_LOW, v); check("R7 held unchanged", v, 32'd40);
        wr(A_CTRL, 32'h2); poll(32'h2, n);
        rd(A_LOW, v); check("R7 newer snapshot", v, 32'd47);

        // R4: writes to data words ignored
        wr(A_LOW, 32'hFFFF_FFFF); wr(A_HIGH, 32'hFFFF_FFFF);
        rd(A_LOW, v);  check("R4 low write ignored", v, 32'd47);
        rd(A_HIGH, v); check("R4 high write ignored", v, 32'h0);

        // R6: re-request while pending does not restart
        wr(A_CTRL, 32'h2); wr(A_CTRL, 32'h2); poll(32'h2, n);
        check("R6 no restart", 32'(n), 32'(DLY - 1));

        // R2: clear wins over a tick on the completing edge
        tick_en = 1'b1;
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); check("R2 clear pending", v & 32'h1, 32'h1);
        poll(32'h1, n);
        tick_en = 1'b0;
        wr(A_CTRL, 32'h2); poll(32'h2, n);
        rd(A_LOW, v); check("R2 zero after clear", v, 32'h0);

        // R8: clear and latch together with counter nonzero and ticking
        ticks(9);
        tick_en = 1'b1;
        wr(A_CTRL, 32'h3); poll(32'h3, n);
        tick_en = 1'b0;
        rd(A_LOW, v); check("R8 snapshot zero", v, 32'h0);
        ticks(4);
        wr(A_CTRL, 32'h2); poll(32'h2, n);
        rd(A_LOW, v); check("R8 counter restarted", v, 32'd4);

        // R5: source field
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, v); check("R5 src readback", v, 32'h8);
        check("R5 src_sel out", 32'(src_sel), 32'h2);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); check("R5 clear-only selects base", v, 32'h1);
        check("R5 src_sel base", 32'(src_sel), 32'h0);
        poll(32'h1, n);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule